// File: doc/BRIEF.md
# Cross-Domain Soft Reset Handshake

This block carries a software-initiated soft reset from a register clock domain into a separate protocol clock domain and reports back when it has taken effect. A reset starts either when software writes 1 to the soft-reset control bit or when the module-level soft-reset request input pulses. Both paths do exactly the same thing. The request travels to the protocol domain as a level. There it produces a single-cycle synchronous reset pulse for the protocol-side registers, and an acknowledge level returns to the register domain.

The control bit reads back as 1 for as long as the reset is in flight. It falls to 0 only after the whole four-phase exchange has finished: request raised, acknowledge raised, request dropped, acknowledge dropped. Software can poll the bit to learn when the reset is complete. While the low-power input reports that clocks are stopped, start attempts are discarded. They are not held for later. The block does not choose which registers get reset, does not make clocks and does not manage power.

Top module: `xdom_srst_hs`

## Requirements
- R1: After the hard asynchronous reset `hard_rst_n`=0, `srst_status`, `reg_srst` and `proto_srst` are all 0. This applies even if the reset arrives in the middle of a handshake, and no protocol pulse follows its release.
- R2: When idle and `lp_stop`=0, a register-clock cycle with `wr_en`=1 and `wr_data`=1 makes `srst_status` read 1 after the next `reg_clk` edge. In the same cycle `reg_srst` is 1 for exactly one `reg_clk` cycle.
- R3: When idle and `lp_stop`=0, a cycle with `mod_srst_req`=1 has the same effect as R2. If the write and the input are both present in one cycle, only one reset results.
- R4: Each accepted request gives exactly one `proto_srst` pulse, one `proto_clk` cycle wide.
- R5: `srst_status` stays 1 until the four-phase round trip is complete. It then returns to 0 by itself, and by then the protocol pulse of R4 has occurred.
- R6: While `srst_status` is 1, further writes of 1 and further `mod_srst_req` pulses are ignored. They give no `reg_srst`, no extra `proto_srst`, and no extension of the pending period.
- R7: A write of 0 (`wr_en`=1, `wr_data`=0), or `wr_data`=1 with `wr_en`=0, never starts a reset.
- R8: While `lp_stop`=1, start attempts are dropped: `srst_status` stays 0 and no pulse appears in either domain, including after `lp_stop` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| reg_clk | input | 1 | Register-domain clock |
| proto_clk | input | 1 | Protocol-domain clock |
| hard_rst_n | input | 1 | Hard reset, active low, asynchronous, both domains |
| wr_en | input | 1 | Write strobe for the soft-reset control bit |
| wr_data | input | 1 | Data bit written to the soft-reset control bit |
| mod_srst_req | input | 1 | Module-level soft-reset request, register domain |
| lp_stop | input | 1 | 1 while clocks are stopped in low power |
| srst_status | output | 1 | Readback of the control bit: 1 while the reset is pending |
| reg_srst | output | 1 | One-cycle synchronous reset pulse, register domain |
| proto_srst | output | 1 | One-cycle synchronous reset pulse, protocol domain |

## Verification
The start logic is driven with every mix of strobe, data bit, external request and low-power level from an idle state. This separates the two accepted start paths from the three lookalikes that must do nothing: a write of 0, data without strobe, and any attempt under low power. A simultaneous write and external request shows whether the two paths merge into one reset or double up. Repeated start attempts while pending distinguish a correctly gated request from one that re-arms. A hard reset in mid-handshake, followed by a quiet interval, shows that no stale request or acknowledge survives in either domain.

// File: rtl/xdom_srst_pkg.sv
// Package: shared types for the cross-domain soft reset handshake.
// Assumes nothing beyond SystemVerilog 2017 enum support.
package xdom_srst_pkg;

    // Register-side handshake phases of the four-phase exchange.
    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,   // no reset pending
        HS_RAISE = 2'd1,   // request high, waiting for acknowledge high
        HS_DRAIN = 2'd2    // request low, waiting for acknowledge low
    } hs_phase_t;

    localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/xdom_bit_sync.sv
// Module: xdom_bit_sync
// Level synchronizer of STAGES flops for one bit into the destination clock.
// Assumes the source holds the level far longer than STAGES destination cycles
// (guaranteed by the four-phase handshake). Hard reset is asynchronous, active low.
module xdom_bit_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/xdom_srst_reg_side.sv
// Module: xdom_srst_reg_side
// Register-domain half of the handshake: accepts a start from the write path
// or the external request, raises the request level, tracks the returning
// acknowledge and reports the pending state. Starts are refused in low power
// and while a reset is pending. Assumes ack_sync is already synchronized.
module xdom_srst_reg_side
    import xdom_srst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_data,
    input  logic ext_req,
    input  logic lp_stop,
    input  logic ack_sync,
    output logic req_level,
    output logic pending,
    output logic srst_pulse
);
    hs_phase_t phase_q, phase_d;
    logic      start_hit;
    logic      pulse_q;

    // A start attempt from either path, qualified by idle and clocks running.
    always_comb begin
        start_hit = (phase_q == HS_IDLE) && !lp_stop
                    && ((wr_en && wr_data) || ext_req);
    end

    // Next-phase selection for the four-phase exchange.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            HS_IDLE:  if (start_hit) phase_d = HS_RAISE;
            HS_RAISE: if (ack_sync)  phase_d = HS_DRAIN;
            HS_DRAIN: if (!ack_sync) phase_d = HS_IDLE;
            default:                 phase_d = HS_IDLE;
        endcase
    end

    // Phase register and one-cycle local reset pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= HS_IDLE;
            pulse_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            pulse_q <= start_hit;
        end
    end

    assign req_level  = (phase_q == HS_RAISE);
    assign pending    = (phase_q != HS_IDLE);
    assign srst_pulse = pulse_q;
endmodule

// File: rtl/xdom_srst_proto_side.sv
// Module: xdom_srst_proto_side
// Protocol-domain half of the handshake: echoes the synchronized request back
// as the acknowledge level and emits a one-cycle reset on the cycle the
// request is first seen. Assumes req_sync is already synchronized.
module xdom_srst_proto_side (
    input  logic clk,
    input  logic rst_n,
    input  logic req_sync,
    output logic ack_level,
    output logic srst_pulse
);
    logic ack_q;

    // Acknowledge follows the synchronized request one cycle later.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= req_sync;
        end
    end

    assign ack_level  = ack_q;
    assign srst_pulse = req_sync && !ack_q;
endmodule

// File: rtl/xdom_srst_hs.sv
// Module: xdom_srst_hs (top)
// Carries a soft reset from the register clock domain to the protocol clock
// domain with a level four-phase request/acknowledge and returns completion
// as the readback bit. Assumes both clocks run while a reset is pending;
// hard_rst_n resets every handshake flop in both domains asynchronously.
module xdom_srst_hs #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic reg_clk,
    input  logic proto_clk,
    input  logic hard_rst_n,
    input  logic wr_en,
    input  logic wr_data,
    input  logic mod_srst_req,
    input  logic lp_stop,
    output logic srst_status,
    output logic reg_srst,
    output logic proto_srst
);
    localparam int unsigned STAGES_EFF =
        (SYNC_STAGES < xdom_srst_pkg::MIN_SYNC_STAGES) ?
        xdom_srst_pkg::MIN_SYNC_STAGES : SYNC_STAGES;

    logic req_to_proto;
    logic req_in_proto;
    logic ack_to_reg;
    logic ack_in_reg;

    xdom_srst_reg_side u_reg (
        .clk       (reg_clk),
        .rst_n     (hard_rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ext_req   (mod_srst_req),
        .lp_stop   (lp_stop),
        .ack_sync  (ack_in_reg),
        .req_level (req_to_proto),
        .pending   (srst_status),
        .srst_pulse(reg_srst)
    );

    xdom_bit_sync #(.STAGES(STAGES_EFF)) u_req_sync (
        .clk    (proto_clk),
        .rst_n  (hard_rst_n),
        .d_async(req_to_proto),
        .q_sync (req_in_proto)
    );

    xdom_srst_proto_side u_proto (
        .clk       (proto_clk),
        .rst_n     (hard_rst_n),
        .req_sync  (req_in_proto),
        .ack_level (ack_to_reg),
        .srst_pulse(proto_srst)
    );

    xdom_bit_sync #(.STAGES(STAGES_EFF)) u_ack_sync (
        .clk    (reg_clk),
        .rst_n  (hard_rst_n),
        .d_async(ack_to_reg),
        .q_sync (ack_in_reg)
    );
endmodule

// File: rtl/xdom_srst_hs_chk.sv
// Module: xdom_srst_hs_chk
// Property checker for xdom_srst_hs, attached by bind. Observes the ports
// plus the request and synchronized acknowledge levels in the register domain.
module xdom_srst_hs_chk (
    input logic reg_clk,
    input logic proto_clk,
    input logic hard_rst_n,
    input logic wr_en,
    input logic wr_data,
    input logic mod_srst_req,
    input logic lp_stop,
    input logic srst_status,
    input logic reg_srst,
    input logic proto_srst,
    input logic req_to_proto,
    input logic ack_in_reg
);
    AST_RESET_QUIET: assert property (@(posedge reg_clk)
        !hard_rst_n |-> (!srst_status && !reg_srst)); // R1

    AST_WRITE_STARTS: assert property (@(posedge reg_clk) disable iff (!hard_rst_n)
        (!srst_status && !lp_stop && wr_en && wr_data) |=> (srst_status && reg_srst)); // R2

    AST_EXT_STARTS: assert property (@(posedge reg_clk) disable iff (!hard_rst_n)
        (!srst_status && !lp_stop && mod_srst_req) |=> (srst_status && reg_srst)); // R3

    AST_REG_PULSE_SINGLE: assert property (@(posedge reg_clk) disable iff (!hard_rst_n)
        reg_srst |=> !reg_srst); // R2

    AST_PROTO_PULSE_SINGLE: assert property (@(posedge proto_clk) disable iff (!hard_rst_n)
        proto_srst |=> !proto_srst); // R4

    AST_CLEAR_AFTER_ROUNDTRIP: assert property (@(posedge reg_clk) disable iff (!hard_rst_n)
        $fell(srst_status) |-> (!req_to_proto && !ack_in_reg)); // R5

    AST_NO_RESTART_PENDING: assert property (@(posedge reg_clk) disable iff (!hard_rst_n)
        srst_status |=> !reg_srst); // R6

    AST_ZERO_WRITE_INERT: assert property (@(posedge reg_clk) disable iff (!hard_rst_n)
        (!srst_status && !mod_srst_req && !(wr_en && wr_data)) |=> (!srst_status && !reg_srst)); // R7

    AST_LOW_POWER_DROP: assert property (@(posedge reg_clk) disable iff (!hard_rst_n)
        (!srst_status && lp_stop) |=> (!srst_status && !reg_srst)); // R8
endmodule

bind xdom_srst_hs xdom_srst_hs_chk u_chk (
    .reg_clk     (reg_clk),
    .proto_clk   (proto_clk),
    .hard_rst_n  (hard_rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .mod_srst_req(mod_srst_req),
    .lp_stop     (lp_stop),
    .srst_status (srst_status),
    .reg_srst    (reg_srst),
    .proto_srst  (proto_srst),
    .req_to_proto(req_to_proto),
    .ack_in_reg  (ack_in_reg)
);

// File: tb/xdom_srst_hs_tb.sv
module xdom_srst_hs_tb;
    logic reg_clk = 1'b0;
    logic proto_clk = 1'b0;
    logic hard_rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic wr_data = 1'b0;
    logic mod_srst_req = 1'b0;
    logic lp_stop = 1'b0;
    logic srst_status, reg_srst, proto_srst;

    int n_tests = 0;
    int n_fail = 0;
    int proto_pulses = 0;
    int proto_wide = 0;
    bit done = 1'b0;

    always #10 reg_clk = ~reg_clk;     // 50 MHz
    always #7  proto_clk = ~proto_clk;

    xdom_srst_hs u_dut (
        .reg_clk(reg_clk), .proto_clk(proto_clk), .hard_rst_n(hard_rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .mod_srst_req(mod_srst_req),
        .lp_stop(lp_stop), .srst_status(srst_status), .reg_srst(reg_srst),
        .proto_srst(proto_srst)
    );

    // Count protocol pulses and any pulse wider than one cycle (R4).
    logic prev_p = 1'b0;
    always @(negedge proto_clk) begin
        if (proto_srst && !prev_p) proto_pulses++;
        if (proto_srst && prev_p)  proto_wide++;
        prev_p = proto_srst;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge reg_clk);
    endtask

    // Wait for the pending bit to clear; returns cycles taken (-1 on timeout).
    task automatic wait_idle(output int took);
        took = -1;
        for (int i = 0; i < 200; i++) begin
            if (!srst_status) begin took = i; break; end
            @(negedge reg_clk);
        end
    endtask

    // {wr_en, wr_data, mod_srst_req, lp_stop, expected_start}
    localparam logic [4:0] VEC [8] = '{
        5'b11001,   // write 1            R2
        5'b10000,   // write 0            R7
        5'b00101,   // external request   R3
        5'b11010,   // write 1 in low pwr R8
        5'b00110,   // external in lp     R8
        5'b11101,   // both paths at once R3
        5'b01000,   // data without strobe R7
        5'b11001    // write 1 again      R2
    };

    initial begin
        int took, base;
        cyc(3);
        check("R1 status in reset", srst_status, 0);
        check("R1 reg_srst in reset", reg_srst, 0);
        check("R1 proto_srst in reset", proto_srst, 0);
        hard_rst_n = 1'b1;
        cyc(3);
        check("R1 status after release", srst_status, 0);

        foreach (VEC[k]) begin
            base = proto_pulses;
            {wr_en, wr_data, mod_srst_req, lp_stop} = VEC[k][4:1];
            cyc(1);
            {wr_en, wr_data, mod_srst_req, lp_stop} = 4'b0;
            check($sformatf("R2/R3/R7/R8 vec%0d status", k), srst_status, VEC[k][0]);
            check($sformatf("R2/R3/R7/R8 vec%0d reg_srst", k), reg_srst, VEC[k][0]);
            cyc(1);
            check($sformatf("R2 vec%0d reg_srst one cycle", k), reg_srst, 0);
            if (VEC[k][0]) begin
                check($sformatf("R5 vec%0d still pending", k), srst_status, 1);
                wait_idle(took);
                check($sformatf("R5 vec%0d cleared", k), int'(took >= 0), 1);
            end else begin
                cyc(30);
                check($sformatf("R8 vec%0d not queued", k), srst_status, 0);
            end
            cyc(4);
            check($sformatf("R4 vec%0d proto pulses", k), proto_pulses - base, int'(VEC[k][0]));
        end
        check("R4 no wide proto pulse", proto_wide, 0);

        // R6: repeated starts while pending.
        base = proto_pulses;
        wr_en = 1'b1; wr_data = 1'b1;
        cyc(1);
        check("R6 first write accepted", srst_status, 1);
        for (int i = 0; i < 5; i++) begin
            mod_srst_req = i[0];
            cyc(1);
            check("R6 no reg_srst while pending", reg_srst, 0);
        end
        wr_en = 1'b0; wr_data = 1'b0; mod_srst_req = 1'b0;
        wait_idle(took);
        check("R6 completes", int'(took >= 0), 1);
        cyc(4);
        check("R6 single proto pulse", proto_pulses - base, 1);

        // R8: low power held, then released with no pending effect.
        lp_stop = 1'b1;
        wr_en = 1'b1; wr_data = 1'b1; mod_srst_req = 1'b1;
        cyc(5);
        check("R8 held lp status", srst_status, 0);
        wr_en = 1'b0; wr_data = 1'b0; mod_srst_req = 1'b0;
        cyc(1);
        lp_stop = 1'b0;
        base = proto_pulses;
        cyc(30);
        check("R8 after lp status", srst_status, 0);
        check("R8 after lp proto", proto_pulses - base, 0);

        // R1: hard reset mid-handshake.
        wr_en = 1'b1; wr_data = 1'b1;
        cyc(1);
        wr_en = 1'b0; wr_data = 1'b0;
        cyc(3);
        hard_rst_n = 1'b0;
        #1;
        check("R1 mid reset status", srst_status, 0);
        check("R1 mid reset proto_srst", proto_srst, 0);
        cyc(2);
        hard_rst_n = 1'b1;
        base = proto_pulses;
        cyc(30);
        check("R1 no stale status", srst_status, 0);
        check("R1 no stale proto pulse", proto_pulses - base, 0);

        // R2/R5: fresh request still works after hard reset.
        mod_srst_req = 1'b1;
        cyc(1);
        mod_srst_req = 1'b0;
        check("R3 start after hard reset", srst_status, 1);
        wait_idle(took);
        cyc(4);
        check("R5 post reset round trip", proto_pulses - base, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule